// File: doc/BRIEF.md
# Contribution-Table Skewed Perceptron Branch Predictor

This block predicts the direction of a conditional branch. Instead of storing perceptron weights and multiplying them by history bits, it stores the precomputed result of that multiply-accumulate for every possible value of a 4-bit history group. The global history is cut into 4-bit groups, and each group value picks one of 16 small saturating counters in a row. One table supplies the row that each group reads. The selected counters from all groups are added, and the sign of the total is the predicted direction.

The counters sit in several tables. Each table indexes its rows with its own hash of the branch address and the history, so two histories that would land on the same counter in one table are usually kept apart in another. The predict port is combinational. It returns the direction, the sum, and the row indices it used. Later, the caller presents the outcome on the update port together with the recorded indices, history and sum. The block trains when the prediction was wrong or the sum was weak. Training moves only the selected counter of each group, by one step toward the outcome.

Top module: `ctp_predictor`

## Requirements
- R1: After reset every counter is zero. For any address and history, the predicted sum is 0 and the predicted direction is taken.
- R2: Group g (g = 0..7) is history bits [4g+3:4g]. Table t (t = 0..3) serves groups 2t and 2t+1. Its row index is (pc >> t) XOR (hist >> 5t), reduced to its low 4 bits, and it is reported on pred_idx[4t+3:4t].
- R3: pred_sum is the 10-bit two's-complement sum of the 8 selected 6-bit signed counters. pred_taken is 1 exactly when pred_sum is non-negative.
- R4: On upd_valid, training happens only when the recorded sum's sign disagrees with upd_taken, or when |upd_sum| is at or below train_thresh. Otherwise no counter changes.
- R5: A training step changes, in each group, only the counter selected by that group's recorded value. The other 15 counters of the row stay unchanged.
- R6: A trained counter moves +1 for taken and -1 for not taken. It saturates at +31 and -32.
- R7: An update takes effect at the next rising clock edge. The predict port then reflects it with no further delay.
- R8: While upd_valid is low, no counter changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all counters |
| pred_pc | input | 16 | Branch address for prediction |
| pred_hist | input | 32 | Global history for prediction |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_sum | output | 10 | Signed sum of selected counters |
| pred_idx | output | 16 | Row index used per table, 4 bits each |
| upd_valid | input | 1 | Update request this cycle |
| upd_taken | input | 1 | Resolved outcome |
| upd_idx | input | 16 | Recorded row indices from prediction |
| upd_hist | input | 32 | Recorded history from prediction |
| upd_sum | input | 10 | Recorded sum from prediction |
| train_thresh | input | 9 | Confidence threshold, unsigned |

## Verification
The assertions assume that every update carries the indices, history and sum that the predict port produced for the same counter state. The trainer trusts these recorded values and does not recompute them. The bench keeps to this assumption. Before each update it computes the indices and sum from its own model of the counters and drives those values onto the update port. Random addresses come from a small pool and histories from a few patterns. This keeps rows hot enough that both saturation limits and the threshold comparison are exercised. Directed sequences push one row to +31 and to -32 everywhere, then change a single group.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
    localparam int CTR_W   = 6;
    localparam int GRP_W   = 4;
    localparam int ENTRIES = 1 << GRP_W;
    localparam int SUM_W   = 10;
    localparam int TH_W    = SUM_W - 1;

    typedef logic signed [CTR_W-1:0] ctr_t;

    localparam ctr_t CTR_MAX = ctr_t'((1 << (CTR_W - 1)) - 1);
    localparam ctr_t CTR_MIN = ctr_t'(-(1 << (CTR_W - 1)));

    function automatic ctr_t sat_step(ctr_t v, logic up);
        ctr_t r;
        if (up) r = (v == CTR_MAX) ? v : ctr_t'(v + ctr_t'(1));
        else    r = (v == CTR_MIN) ? v : ctr_t'(v - ctr_t'(1));
        return r;
    endfunction
endpackage

// File: rtl/ctp_hash.sv
module ctp_hash #(
    parameter int TBL_ID = 0,
    parameter int PC_W   = 16,
    parameter int HIST_W = 32,
    parameter int IDX_W  = 4,
    parameter int HSHIFT = 5
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    localparam int PC_LO = TBL_ID;
    localparam int H_LO  = TBL_ID * HSHIFT;

    always_comb begin
        idx = pc[PC_LO +: IDX_W] ^ hist[H_LO +: IDX_W];
    end
endmodule

// File: rtl/ctp_table.sv
module ctp_table
    import ctp_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int GPT   = 2,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       rd_idx,
    input  logic [GPT*GRP_W-1:0]   rd_grp,
    output logic [GPT*CTR_W-1:0]   rd_val,
    input  logic                   wr_en,
    input  logic                   wr_dir,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [GPT*GRP_W-1:0]   wr_grp
);
    typedef struct {
        ctr_t mem [ROWS][GPT][ENTRIES];
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    logic [GRP_W-1:0] rd_grp_a [GPT];
    logic [GRP_W-1:0] wr_grp_a [GPT];

    for (genvar k = 0; k < GPT; k++) begin : g_unpack
        assign rd_grp_a[k] = rd_grp[k*GRP_W +: GRP_W];
        assign wr_grp_a[k] = wr_grp[k*GRP_W +: GRP_W];
        assign rd_val[k*CTR_W +: CTR_W] = st_q.mem[rd_idx][k][rd_grp_a[k]];
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int k = 0; k < GPT; k++) begin
                st_d.mem[wr_idx][k][wr_grp_a[k]] =
                    sat_step(st_q.mem[wr_idx][k][wr_grp_a[k]], wr_dir);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int k = 0; k < GPT; k++)
                    for (int e = 0; e < ENTRIES; e++)
                        st_q.mem[r][k][e] <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < GPT; k++) begin : g_chk
        // R6
        sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_dir && st_q.mem[wr_idx][k][wr_grp_a[k]] == CTR_MAX)
            |=> st_q.mem[$past(wr_idx)][k][$past(wr_grp_a[k])] == CTR_MAX);
        // R6
        sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_dir && st_q.mem[wr_idx][k][wr_grp_a[k]] == CTR_MIN)
            |=> st_q.mem[$past(wr_idx)][k][$past(wr_grp_a[k])] == CTR_MIN);
        // R5
        step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=>
            ((st_q.mem[$past(wr_idx)][k][$past(wr_grp_a[k])] ==
                  $past(st_q.mem[wr_idx][k][wr_grp_a[k]])) ||
             (st_q.mem[$past(wr_idx)][k][$past(wr_grp_a[k])] ==
                  ctr_t'($past(st_q.mem[wr_idx][k][wr_grp_a[k]]) + ctr_t'(1))) ||
             (st_q.mem[$past(wr_idx)][k][$past(wr_grp_a[k])] ==
                  ctr_t'($past(st_q.mem[wr_idx][k][wr_grp_a[k]]) - ctr_t'(1)))));
    end
endmodule

// File: rtl/ctp_adder.sv
module ctp_adder
    import ctp_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N*CTR_W-1:0]     vals,
    output logic signed [SUM_W-1:0] sum
);
    logic signed [SUM_W-1:0] ext [N];

    for (genvar i = 0; i < N; i++) begin : g_ext
        assign ext[i] = {{(SUM_W-CTR_W){vals[i*CTR_W+CTR_W-1]}},
                         vals[i*CTR_W +: CTR_W]};
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) sum = sum + ext[i];
    end
endmodule

// File: rtl/ctp_predictor.sv
module ctp_predictor
    import ctp_pkg::*;
#(
    parameter int NT     = 4,
    parameter int GPT    = 2,
    parameter int ROWS   = 16,
    parameter int PC_W   = 16,
    parameter int HSHIFT = 5,
    localparam int IDX_W  = $clog2(ROWS),
    localparam int NG     = NT * GPT,
    localparam int HIST_W = NG * GRP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PC_W-1:0]         pred_pc,
    input  logic [HIST_W-1:0]       pred_hist,
    output logic                    pred_taken,
    output logic signed [SUM_W-1:0] pred_sum,
    output logic [NT*IDX_W-1:0]     pred_idx,
    input  logic                    upd_valid,
    input  logic                    upd_taken,
    input  logic [NT*IDX_W-1:0]     upd_idx,
    input  logic [HIST_W-1:0]       upd_hist,
    input  logic signed [SUM_W-1:0] upd_sum,
    input  logic [TH_W-1:0]         train_thresh
);
    logic [NG*CTR_W-1:0] sel_vals;
    logic                train_en;
    logic                upd_correct;
    logic [SUM_W:0]      upd_mag;

    for (genvar t = 0; t < NT; t++) begin : g_tbl
        ctp_hash #(
            .TBL_ID(t), .PC_W(PC_W), .HIST_W(HIST_W),
            .IDX_W(IDX_W), .HSHIFT(HSHIFT)
        ) hash_i (
            .pc  (pred_pc),
            .hist(pred_hist),
            .idx (pred_idx[t*IDX_W +: IDX_W])
        );

        ctp_table #(.ROWS(ROWS), .GPT(GPT)) tbl_i (
            .clk   (clk),
            .rst_n (rst_n),
            .rd_idx(pred_idx[t*IDX_W +: IDX_W]),
            .rd_grp(pred_hist[t*GPT*GRP_W +: GPT*GRP_W]),
            .rd_val(sel_vals[t*GPT*CTR_W +: GPT*CTR_W]),
            .wr_en (train_en),
            .wr_dir(upd_taken),
            .wr_idx(upd_idx[t*IDX_W +: IDX_W]),
            .wr_grp(upd_hist[t*GPT*GRP_W +: GPT*GRP_W])
        );
    end

    ctp_adder #(.N(NG)) adder_i (
        .vals(sel_vals),
        .sum (pred_sum)
    );

    always_comb begin
        pred_taken  = !pred_sum[SUM_W-1];
        upd_correct = (!upd_sum[SUM_W-1]) == upd_taken;
        upd_mag     = upd_sum[SUM_W-1] ? (SUM_W+1)'(-$signed({upd_sum[SUM_W-1], upd_sum}))
                                       : {1'b0, upd_sum};
        train_en    = upd_valid && (!upd_correct || upd_mag <= (SUM_W+1)'(train_thresh));
    end

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> (!($stable(pred_pc) && $stable(pred_hist)) || $stable(pred_sum)));

    // R4
    confident_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && ((upd_sum >= 0) == upd_taken) &&
         ((upd_sum >= 0 ? upd_sum : -upd_sum) > $signed({1'b0, train_thresh})))
        |=> (!($stable(pred_pc) && $stable(pred_hist)) || $stable(pred_sum)));

    // R3
    sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_sum >= -(NG * 32)) && (pred_sum <= NG * 31));
endmodule

// File: tb/ctp_predictor_tb.sv
module ctp_predictor_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] pred_pc = '0;
    logic [31:0] pred_hist = '0;
    logic        pred_taken;
    logic signed [9:0] pred_sum;
    logic [15:0] pred_idx;
    logic        upd_valid = 0;
    logic        upd_taken = 0;
    logic [15:0] upd_idx = '0;
    logic [31:0] upd_hist = '0;
    logic signed [9:0] upd_sum = '0;
    logic [8:0]  train_thresh = '0;

    int n_checks = 0;
    int n_fail = 0;
    int ref_m [4][16][2][16];

    always #2 clk = ~clk;

    ctp_predictor dut_i (
        .clk(clk), .rst_n(rst_n),
        .pred_pc(pred_pc), .pred_hist(pred_hist),
        .pred_taken(pred_taken), .pred_sum(pred_sum), .pred_idx(pred_idx),
        .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_idx(upd_idx),
        .upd_hist(upd_hist), .upd_sum(upd_sum), .train_thresh(train_thresh)
    );

    function automatic int m_idx(int t, logic [15:0] pc, logic [31:0] h);
        return int'(((pc >> t) ^ 16'(h >> (5 * t))) & 16'hF);
    endfunction

    function automatic int m_grp(logic [31:0] h, int g);
        return int'((h >> (4 * g)) & 32'hF);
    endfunction

    function automatic int m_sum(logic [15:0] pc, logic [31:0] h);
        int s = 0;
        for (int t = 0; t < 4; t++)
            for (int k = 0; k < 2; k++)
                s += ref_m[t][m_idx(t, pc, h)][k][m_grp(h, 2 * t + k)];
        return s;
    endfunction

    function automatic logic [15:0] m_idx_vec(logic [15:0] pc, logic [31:0] h);
        logic [15:0] v;
        for (int t = 0; t < 4; t++) v[t*4 +: 4] = 4'(m_idx(t, pc, h));
        return v;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic m_train(logic [15:0] pc, logic [31:0] h, int s, logic out, int thr);
        bit correct = ((s >= 0) == out);
        int mag = (s < 0) ? -s : s;
        if (!correct || mag <= thr) begin
            for (int t = 0; t < 4; t++)
                for (int k = 0; k < 2; k++) begin
                    int r = m_idx(t, pc, h);
                    int e = m_grp(h, 2 * t + k);
                    if (out) begin
                        if (ref_m[t][r][k][e] < 31) ref_m[t][r][k][e]++;
                    end else begin
                        if (ref_m[t][r][k][e] > -32) ref_m[t][r][k][e]--;
                    end
                end
        end
    endtask

    // predict, check, then optionally update at the next rising edge
    task automatic step(logic [15:0] pc, logic [31:0] h, bit do_upd, logic out,
                        int thr, string req);
        int s;
        @(negedge clk);
        pred_pc = pc;
        pred_hist = h;
        #1;
        s = m_sum(pc, h);
        chk({req, "/R3 sum"}, int'(pred_sum), s);
        chk({req, "/R3 taken"}, int'(pred_taken), (s >= 0) ? 1 : 0);
        chk({req, "/R2 idx"}, int'(pred_idx), int'(m_idx_vec(pc, h)));
        upd_valid = do_upd;
        upd_taken = out;
        upd_idx = m_idx_vec(pc, h);
        upd_hist = h;
        upd_sum = 10'(s);
        train_thresh = 9'(thr);
        @(posedge clk);
        if (do_upd) m_train(pc, h, s, out, thr);
        #1;
        upd_valid = 0;
    endtask

    logic [15:0] pc_pool [8];
    logic [31:0] h_pool [6];

    initial begin
        for (int t = 0; t < 4; t++)
            for (int r = 0; r < 16; r++)
                for (int k = 0; k < 2; k++)
                    for (int e = 0; e < 16; e++) ref_m[t][r][k][e] = 0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            logic [15:0] pc = 16'($urandom);
            logic [31:0] h = $urandom;
            @(negedge clk);
            pred_pc = pc; pred_hist = h;
            #1;
            chk("R1 sum zero", int'(pred_sum), 0);
            chk("R1 taken", int'(pred_taken), 1);
        end

        // R6: saturate upward, always train (thresh max)
        for (int i = 0; i < 40; i++) step(16'h0123, 32'h0000_0000, 1, 1, 511, "R6 up");
        @(negedge clk); pred_pc = 16'h0123; pred_hist = 32'h0; #1;
        chk("R6 max sum", int'(pred_sum), 248);
        // R4: confident and correct, no change
        step(16'h0123, 32'h0, 1, 1, 100, "R4 hold");
        @(negedge clk); #1;
        chk("R4 no train", int'(pred_sum), 248);
        // R6: saturate downward
        for (int i = 0; i < 80; i++) step(16'h0123, 32'h0, 1, 0, 511, "R6 down");
        @(negedge clk); pred_pc = 16'h0123; pred_hist = 32'h0; #1;
        chk("R6 min sum", int'(pred_sum), -256);
        // R5: bit 4 changes only group 1 value, same rows everywhere
        pred_hist = 32'h0000_0010; #1;
        chk("R5 neighbour untouched", int'(pred_sum), -224);
        chk("R5 taken", int'(pred_taken), 0);

        // R8: idle cycles with junk on update inputs
        @(negedge clk);
        pred_pc = 16'h0123; pred_hist = 32'h0;
        upd_valid = 0; upd_taken = 1; upd_idx = m_idx_vec(16'h0123, 32'h0);
        upd_hist = 32'h0; upd_sum = -10'sd1; train_thresh = 9'd511;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 idle hold", int'(pred_sum), -256);

        // R7: one update visible right after the edge
        step(16'h0123, 32'h0000_0010, 1, 1, 511, "R7 upd");
        @(negedge clk); pred_pc = 16'h0123; pred_hist = 32'h0000_0010; #1;
        chk("R7 next cycle", int'(pred_sum), -216);

        // random mix
        for (int i = 0; i < 8; i++) pc_pool[i] = 16'($urandom);
        for (int i = 0; i < 6; i++) h_pool[i] = $urandom;
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] pc = pc_pool[$urandom % 8];
            logic [31:0] h = h_pool[$urandom % 6];
            if ($urandom % 4 == 0) h ^= (32'h1 << ($urandom % 32));
            step(pc, h, ($urandom % 8) != 0, 1'($urandom), int'($urandom % 40), "R4 rand");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule